// File: doc/BRIEF.md
# Four-Lane Horizontal Five-Pixel Binner

This block sums runs of five horizontally adjacent pixels from a video line that arrives four pixels at a time. A bin almost never starts or ends on a word edge, so the block keeps the previous accepted word and uses a phase counter with five states to rebuild each five-pixel group. Each group combines the tail of the held word with the head of the current word. One pipelined adder tree then produces one widened sum per group, marked by a valid strobe.

Every five accepted words yield four bins, and one of those five words forms no group. The output strobe therefore has gaps even when the input is gapless. A start-of-line pulse realigns the phase, so every line is binned from its own first pixel. Pixels left over at the end of a line are dropped.

Top module: `bin5_binner`

## Requirements
- R1: Each cycle with `vld_i` high delivers four pixels. Lane 0 sits in the least significant PIX_W bits and is the leftmost pixel. Every output is the sum of five consecutive pixels of the line, and bins appear in line order.
- R2: The phase counter moves only on cycles with `vld_i` high, cycling through 0,1,2,3,4 and then back to 0. Cycles without valid, whatever `pix_i` carries, change neither the phase nor the results.
- R3: A valid word taken in phase 0 forms no group. A valid word taken in phase p (1 to 4) forms one group: the last 5-p pixels of the held word, followed by the first p pixels of the current word.
- R4: Gapless input yields exactly four bins for every five words, and `vld_o` is never high on more than four consecutive cycles.
- R5: A bin's sum and strobe appear after the third rising edge that follows the edge sampling the word that completes the group: one regrouping register plus three adder stages.
- R6: Pixels are 12 bits wide and sums 16 bits wide. Five pixels of 4095 give 20475 with no overflow.
- R7: `sol_i` forces the phase to 0 and drops any partial group. If `sol_i` arrives together with `vld_i`, that word is the line's first word, in phase 0. If `sol_i` arrives alone, the next valid word is the first word.
- R8: A 1920-pixel line (480 words) yields exactly 384 bins, and a 52-pixel line yields 10.
- R9: While reset is held and after its release, `vld_o` stays low until a group is formed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sol_i | input | 1 | Start-of-line pulse, realigns the phase |
| vld_i | input | 1 | Input word valid |
| pix_i | input | 48 | Four pixels; lane 0 is least significant and leftmost |
| vld_o | output | 1 | Binned sum valid |
| sum_o | output | 16 | Sum of five adjacent pixels |

## Verification
The assertions take for granted that `sol_i` and `vld_i` are known after reset and that each line opens with `sol_i`, either alone or on the line's first valid word. They also take for granted that pixel values fit PIX_W, so a sum can never exceed five full-scale pixels. The stimulus keeps to these limits. It opens every line with a start pulse, using both forms. It keeps pixels inside 12 bits and drives random junk on `pix_i` only while `vld_i` is low. It inserts random valid gaps so that phase holding is exercised in every phase.

// File: rtl/bin5_pkg.sv
package bin5_pkg;
  localparam int GRP   = 5;              // pixels per bin
  localparam int LANES = GRP - 1;        // pixels per input word
  localparam int PH_W  = $clog2(GRP);    // phase counter width
endpackage

// File: rtl/bin5_regroup.sv
module bin5_regroup
  import bin5_pkg::*;
#(
  parameter int PIX_W = 12
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   sol_i,
  input  logic                   vld_i,
  input  logic [LANES*PIX_W-1:0] pix_i,
  output logic                   grp_vld_o,
  output logic [GRP*PIX_W-1:0]   grp_o
);
  logic [PH_W-1:0]        ph_q, ph_d, ph_eff;
  logic [LANES*PIX_W-1:0] hold_q;
  logic [GRP*PIX_W-1:0]   grp_q, grp_d;
  logic                   gvld_q, gvld_d;

  // next-state: phase
  always_comb begin
    ph_eff = sol_i ? '0 : ph_q;
    ph_d   = ph_eff;
    if (vld_i) begin
      if (ph_eff == PH_W'(GRP-1)) ph_d = '0;
      else                        ph_d = ph_eff + 1'b1;
    end
    gvld_d = vld_i && (ph_eff != '0);
  end

  // next-state: group selection, held tail first, then new head
  always_comb begin
    int pe;
    int held;
    pe    = (ph_eff == '0) ? 1 : int'(ph_eff);
    held  = GRP - pe;
    grp_d = '0;
    for (int j = 0; j < GRP; j++) begin
      if (j < held) grp_d[j*PIX_W +: PIX_W] = hold_q[(pe-1+j)*PIX_W +: PIX_W];
      else          grp_d[j*PIX_W +: PIX_W] = pix_i[(j-held)*PIX_W +: PIX_W];
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= '0;
      gvld_q <= 1'b0;
    end else begin
      ph_q   <= ph_d;
      gvld_q <= gvld_d;
    end
  end

  always_ff @(posedge clk) begin
    if (vld_i)  hold_q <= pix_i;
    if (gvld_d) grp_q  <= grp_d;
  end

  assign grp_vld_o = gvld_q;
  assign grp_o     = grp_q;

  assert_phase0_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_i && (sol_i || ph_q == '0)) |=> !grp_vld_o);
  assert_phase_forms_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_i && !sol_i && ph_q != '0) |=> grp_vld_o);
  assert_idle_no_group_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!vld_i && !sol_i) |=> (!grp_vld_o && $stable(ph_q)));
  assert_sol_resets_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (sol_i && !vld_i) |=> (ph_q == '0));
endmodule

// File: rtl/bin5_addtree.sv
module bin5_addtree
  import bin5_pkg::*;
#(
  parameter int PIX_W = 12,
  parameter int SUM_W = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_vld_i,
  input  logic [GRP*PIX_W-1:0] grp_i,
  output logic                 out_vld_o,
  output logic [SUM_W-1:0]     sum_o
);
  localparam int STG = 3;

  logic [STG-1:0]   vld_q, vld_d;
  logic [SUM_W-1:0] s1a_q, s1b_q, s1c_q, s1a_d, s1b_d, s1c_d;
  logic [SUM_W-1:0] s2a_q, s2b_q, s2a_d, s2b_d;
  logic [SUM_W-1:0] s3_q, s3_d;

  function automatic logic [SUM_W-1:0] px(input logic [GRP*PIX_W-1:0] g, input int k);
    return SUM_W'(g[k*PIX_W +: PIX_W]);
  endfunction

  always_comb begin
    vld_d = {vld_q[STG-2:0], in_vld_i};
    s1a_d = px(grp_i, 0) + px(grp_i, 1);
    s1b_d = px(grp_i, 2) + px(grp_i, 3);
    s1c_d = px(grp_i, 4);
    s2a_d = s1a_q + s1b_q;
    s2b_d = s1c_q;
    s3_d  = s2a_q + s2b_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= '0;
    else        vld_q <= vld_d;
  end

  always_ff @(posedge clk) begin
    if (in_vld_i) begin
      s1a_q <= s1a_d;
      s1b_q <= s1b_d;
      s1c_q <= s1c_d;
    end
    if (vld_q[0]) begin
      s2a_q <= s2a_d;
      s2b_q <= s2b_d;
    end
    if (vld_q[1]) s3_q <= s3_d;
  end

  assign out_vld_o = vld_q[STG-1];
  assign sum_o     = s3_q;
endmodule

// File: rtl/bin5_binner.sv
module bin5_binner
  import bin5_pkg::*;
#(
  parameter int PIX_W = 12,
  parameter int SUM_W = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   sol_i,
  input  logic                   vld_i,
  input  logic [LANES*PIX_W-1:0] pix_i,
  output logic                   vld_o,
  output logic [SUM_W-1:0]       sum_o
);
  localparam int MAXSUM = GRP * ((1 << PIX_W) - 1);

  logic                 gvld;
  logic [GRP*PIX_W-1:0] grp;

  bin5_regroup #(.PIX_W(PIX_W)) u_regroup (
    .clk(clk), .rst_n(rst_n), .sol_i(sol_i), .vld_i(vld_i), .pix_i(pix_i),
    .grp_vld_o(gvld), .grp_o(grp)
  );

  bin5_addtree #(.PIX_W(PIX_W), .SUM_W(SUM_W)) u_addtree (
    .clk(clk), .rst_n(rst_n), .in_vld_i(gvld), .grp_i(grp),
    .out_vld_o(vld_o), .sum_o(sum_o)
  );

  assert_latency_R5: assert property (@(posedge clk) disable iff (!rst_n)
    gvld |-> ##3 vld_o);
  assert_no_spurious_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !gvld |-> ##3 !vld_o);
  assert_max_run_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(vld_o, 4) && $past(vld_o, 3) && $past(vld_o, 2) && $past(vld_o)) |-> !vld_o);
  assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
    vld_o |-> (32'(sum_o) <= 32'(MAXSUM)));
endmodule

// File: tb/bin5_binner_bench.sv
module bin5_binner_bench;
  localparam int PW = 12;
  localparam int SW = 16;

  logic clk = 1'b0;
  logic rst_n;
  logic sol_i, vld_i;
  logic [4*PW-1:0] pix_i;
  logic vld_o;
  logic [SW-1:0] sum_o;

  bin5_binner #(.PIX_W(PW), .SUM_W(SW)) u_bin5_binner (
    .clk(clk), .rst_n(rst_n), .sol_i(sol_i), .vld_i(vld_i), .pix_i(pix_i),
    .vld_o(vld_o), .sum_o(sum_o)
  );

  always #5 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int checks = 0, fails = 0;
  int exp_sum[$];
  int exp_cyc[$];
  int exp_lid[$];
  int line_cnt[8];
  int run = 0, max_run = 0;
  bit done = 0;
  int cur_mode = 0;

  function automatic int pval(int lid, int idx);
    if (lid == 3) return 4095;
    return (lid * 97 + idx * 13 + (idx / 7) * 5) % 4096;
  endfunction

  task automatic chk(bit ok, string req, int act, int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  // monitor
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (vld_o) begin
        run++;
        if (run > max_run) max_run = run;
        if (exp_sum.size() == 0) begin
          chk(0, "R1 unexpected output", int'(sum_o), -1);
        end else begin
          int es, ec, el;
          es = exp_sum.pop_front();
          ec = exp_cyc.pop_front();
          el = exp_lid.pop_front();
          chk(int'(sum_o) == es, "R1 R2 R3 R6 bin sum", int'(sum_o), es);
          chk(cyc == ec, "R5 output cycle", cyc, ec);
          line_cnt[el]++;
        end
      end else run = 0;
    end
  end

  task automatic drive_line(int lid, int nwords, bit sol_with, int gapmax);
    int pushed = 0;
    if (!sol_with) begin
      @(negedge clk);
      sol_i = 1'b1; vld_i = 1'b0; pix_i = {$urandom, $urandom};
      @(negedge clk);
      sol_i = 1'b0;
    end
    for (int w = 0; w < nwords; w++) begin
      int g;
      g = (gapmax > 0) ? int'($urandom % (gapmax + 1)) : 0;
      for (int k = 0; k < g; k++) begin
        @(negedge clk);
        sol_i = 1'b0; vld_i = 1'b0; pix_i = {$urandom, $urandom};
      end
      @(negedge clk);
      sol_i = (w == 0) && sol_with;
      vld_i = 1'b1;
      for (int l = 0; l < 4; l++) pix_i[l*PW +: PW] = PW'(pval(lid, 4*w + l));
      while (pushed < (4 * (w + 1)) / 5) begin
        int s = 0;
        for (int j = 0; j < 5; j++) s += pval(lid, 5 * pushed + j);
        exp_sum.push_back(s);
        exp_cyc.push_back(cyc + 1 + 3);
        exp_lid.push_back(lid);
        pushed++;
      end
    end
    @(negedge clk);
    vld_i = 1'b0; sol_i = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0; sol_i = 1'b0; vld_i = 1'b0; pix_i = '0;
    repeat (3) @(negedge clk);
    chk(vld_o == 1'b0, "R9 reset vld_o", int'(vld_o), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(vld_o == 1'b0, "R9 idle after reset", int'(vld_o), 0);

    drive_line(0, 480, 1'b0, 2);   // full line, random gaps
    drive_line(1, 13, 1'b1, 1);    // short line, 2 leftover pixels dropped (R7)
    drive_line(2, 25, 1'b0, 0);    // gapless
    drive_line(3, 20, 1'b1, 0);    // full-scale pixels
    drive_line(4, 480, 1'b1, 3);   // full line, sol with first word
    repeat (12) @(negedge clk);

    chk(exp_sum.size() == 0, "R1 all bins emitted", exp_sum.size(), 0);
    chk(line_cnt[0] == 384, "R8 bins in 1920-pixel line", line_cnt[0], 384);
    chk(line_cnt[1] == 10, "R8 R7 bins in 52-pixel line", line_cnt[1], 10);
    chk(line_cnt[2] == 20, "R4 bins per 25 gapless words", line_cnt[2], 20);
    chk(line_cnt[3] == 16, "R6 full-scale bins", line_cnt[3], 16);
    chk(line_cnt[4] == 384, "R8 R7 bins with sol on data", line_cnt[4], 384);
    chk(max_run <= 4, "R4 longest valid run", max_run, 4);
    chk(max_run == 4, "R4 gapless run reaches four", max_run, 4);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule